// File: doc/BRIEF.md
# Peripheral Power Gating Controller

This block gives a group of peripherals two levels of power control and sits between a simple register bus and their register files. Each peripheral has a run bit, which is bit 0 of its first register. Clearing the run bit stops the peripheral's activity, but its registers can still be read and written. A separate module-off bit lives in one of three shut-off registers. Setting the module-off bit removes the peripheral's clock and also cuts off its register interface.

For every peripheral the block produces three signals: a glitch-free gated clock, a register-access enable and a run enable. Each peripheral is a stand-in register file of `NREG` registers. The last register in each file is an activity counter. The counter advances on every cycle in which the peripheral is running.

A bus write lands on the cycle's rising edge. Reads are combinational from the address.

Top module: `pmd_gate`

## Requirements
- R1: Addresses 0, 1 and 2 hold the three shut-off registers. Bit `p%DW` of register `p/DW` is the module-off bit of peripheral p. All three registers reset to zero. They can be read and written. Any bit at or above `NPER` reads zero and cannot be set.
- R2: `acc_en[p]` is high exactly when peripheral p is not shut off. `gclk_en[p]` is captured only while `clk` is low, so at each rising edge it equals the inverse of the module-off bit. `gclk[p]` is `clk` gated by `gclk_en[p]`.
- R3: A bus write to any register of a shut-off peripheral has no effect.
- R4: A read of any register of a shut-off peripheral returns zero.
- R5: While a peripheral is shut off, all its registers sit at their reset value of zero. After the module-off bit is cleared, every register reads zero.
- R6: Peripheral p's register r is at address `PBASE + p*NREG + r`. While p is not shut off, its registers can be read and written whatever its run bit is. The counter register (`r = NREG-1`) holds when the run bit is 0.
- R7: `run_en[p]` is high exactly when the run bit is 1 and p is not shut off. While `run_en[p]` is high, the counter increments by one each cycle and wraps modulo 2^DW.
- R8: A bus write to the counter of a running peripheral takes precedence over the increment in that cycle.
- R9: An address that maps to no register reads zero, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bus write strobe |
| addr | input | AW | Bus address |
| wdata | input | DW | Bus write data |
| rdata | output | DW | Bus read data (combinational) |
| gclk_en | output | NPER | Latched clock-gate enable per peripheral |
| gclk | output | NPER | Gated clock per peripheral |
| acc_en | output | NPER | Register-access enable per peripheral |
| run_en | output | NPER | Run enable per peripheral |

## Verification
Directed sequences come first. They write and read one peripheral with its run bit off, then with it on, then write the counter while it runs. This separates stopped operation from blocked access. Next, the module-off bit is set and the sequence tries writes and reads, then clears the bit and reads the file back. This separates R3 and R4 from the reset-on-release behaviour in R5. Saturating writes to the shut-off registers and accesses to unmapped addresses check masking and decoding. A long phase of mixed random writes and reads is compared on every clock against a behavioural model, which catches interactions between peripherals.

// File: rtl/pmd_gate.sv
module pmd_gate #(
  parameter int NPER  = 6,
  parameter int NREG  = 4,
  parameter int DW    = 8,
  parameter int AW    = 8,
  parameter int PBASE = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [NPER-1:0] gclk_en,
  output logic [NPER-1:0] gclk,
  output logic [NPER-1:0] acc_en,
  output logic [NPER-1:0] run_en
);
  localparam int NDREG = 3;
  localparam int DBITS = NDREG * DW;
  localparam int RW    = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int PW    = (NPER > 1) ? $clog2(NPER) : 1;
  localparam int PEND  = PBASE + NPER * NREG;
  localparam logic [DBITS-1:0] DMASK = {{(DBITS-NPER){1'b0}}, {NPER{1'b1}}};

  logic [DBITS-1:0] dis_q;
  logic [NPER-1:0][NREG-1:0][DW-1:0] regs;
  logic [NPER-1:0] md;
  logic [AW-1:0] off;
  logic [PW-1:0] psel;
  logic [RW-1:0] ridx;
  logic in_per;

  assign md     = dis_q[NPER-1:0];
  assign off    = addr - AW'(PBASE);
  assign psel   = PW'(off >> RW);
  assign ridx   = off[RW-1:0];
  assign in_per = (int'(addr) >= PBASE) && (int'(addr) < PEND);
  assign acc_en = ~md;

  always_ff @(posedge clk) begin
    if (rst) dis_q <= '0;
    else
      for (int i = 0; i < NDREG; i++)
        if (wr_en && int'(addr) == i) dis_q[i*DW +: DW] <= wdata & DMASK[i*DW +: DW];
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NPER; p++) begin
      if (rst || md[p]) regs[p] <= '0;
      else begin
        if (run_en[p]) regs[p][NREG-1] <= regs[p][NREG-1] + 1'b1;
        if (wr_en && in_per && int'(psel) == p) regs[p][ridx] <= wdata;
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NPER; p++) run_en[p] = regs[p][0][0] & ~md[p];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NDREG; i++)
      if (int'(addr) == i) rdata = dis_q[i*DW +: DW];
    if (in_per && !md[psel]) rdata = regs[psel][ridx];
  end

  always_latch begin
    if (!clk) gclk_en = ~md;
  end

  assign gclk = {NPER{clk}} & gclk_en;
endmodule

module pmd_gate_chk #(
  parameter int NPER  = 6,
  parameter int NREG  = 4,
  parameter int DW    = 8,
  parameter int AW    = 8,
  parameter int PBASE = 16
) (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [NPER-1:0] gclk_en,
  input logic [NPER-1:0] run_en,
  input logic [3*DW-1:0] dis_q,
  input logic [NPER-1:0][NREG-1:0][DW-1:0] regs
);
  assert_reset_clear_R1: assert property (@(posedge clk) $fell(rst) |-> dis_q == '0);

  for (genvar p = 0; p < NPER; p++) begin : g_p
    logic hit;
    logic hit_cnt;
    assign hit     = (int'(addr) >= PBASE + p*NREG) && (int'(addr) < PBASE + (p+1)*NREG);
    assign hit_cnt = int'(addr) == PBASE + p*NREG + NREG - 1;

    assert_gate_en_R2: assert property (@(posedge clk) disable iff (rst)
      gclk_en[p] == !dis_q[p]);
    assert_wr_blocked_R3: assert property (@(posedge clk) disable iff (rst)
      (dis_q[p] && wr_en && hit) |=> regs[p] == '0);
    assert_rd_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (dis_q[p] && hit) |-> rdata == '0);
    assert_off_cleared_R5: assert property (@(posedge clk) disable iff (rst)
      ($past(dis_q[p]) && dis_q[p]) |-> regs[p] == '0);
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (!run_en[p] && !dis_q[p] && !(wr_en && hit)) |=> $stable(regs[p]));
    assert_run_R7: assert property (@(posedge clk) disable iff (rst)
      run_en[p] |-> (!dis_q[p] && regs[p][0][0]));
    assert_cnt_write_R8: assert property (@(posedge clk) disable iff (rst)
      (run_en[p] && wr_en && hit_cnt) |=> regs[p][NREG-1] == $past(wdata));
  end
endmodule

bind pmd_gate pmd_gate_chk #(.NPER(NPER), .NREG(NREG), .DW(DW), .AW(AW), .PBASE(PBASE)) u_chk (.*);

// File: tb/sim_pmd_gate.sv
module sim_pmd_gate;
  localparam int NPER = 6, NREG = 4, DW = 8, AW = 8, PBASE = 16;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NPER-1:0] gclk_en, gclk, acc_en, run_en;

  pmd_gate #(.NPER(NPER), .NREG(NREG), .DW(DW), .AW(AW), .PBASE(PBASE)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .gclk_en(gclk_en), .gclk(gclk), .acc_en(acc_en), .run_en(run_en));

  always #5 clk = ~clk;

  int ncmp = 0, nbad = 0;
  int dis [3];
  int m [NPER][NREG];
  string tag = "R6";
  bit done = 0;

  function automatic bit off_p(int p);
    return dis[p / DW][p % DW];
  endfunction

  function automatic int model_rd(int a);
    if (a < 3) return dis[a];
    if (a >= PBASE && a < PBASE + NPER*NREG) begin
      if (off_p((a - PBASE) / NREG)) return 0;
      return m[(a - PBASE) / NREG][(a - PBASE) % NREG];
    end
    return 0;
  endfunction

  function automatic string rd_tag(int a);
    if (a < 3) return "R1";
    if (a >= PBASE && a < PBASE + NPER*NREG)
      return off_p((a - PBASE) / NREG) ? "R4" : tag;
    return "R9";
  endfunction

  task automatic cmp(string r, int act, int exp);
    ncmp++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", r, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int a, snap [3];
    a = int'(addr);
    snap = dis;
    if (rst) begin
      foreach (dis[i]) dis[i] = 0;
      foreach (m[p, r]) m[p][r] = 0;
    end else begin
      for (int p = 0; p < NPER; p++) begin
        if (snap[p / DW][p % DW]) begin
          for (int r = 0; r < NREG; r++) m[p][r] = 0;
        end else begin
          if (m[p][0] % 2 == 1) m[p][NREG-1] = (m[p][NREG-1] + 1) % 256;
          if (wr_en && a >= PBASE + p*NREG && a < PBASE + (p+1)*NREG)
            m[p][a - PBASE - p*NREG] = int'(wdata);
        end
      end
      if (wr_en && a < 3) begin
        int v;
        v = int'(wdata);
        for (int b = 0; b < DW; b++)
          if (a*DW + b >= NPER) v[b] = 1'b0;
        dis[a] = v;
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (!rst && !done) begin
      cmp(rd_tag(int'(addr)), int'(rdata), model_rd(int'(addr)));
      for (int p = 0; p < NPER; p++) begin
        cmp("R2", int'(acc_en[p]), int'(!off_p(p)));
        cmp("R2", int'(gclk_en[p]), int'(!off_p(p)));
        cmp("R7", int'(run_en[p]), int'(!off_p(p) && (m[p][0] % 2 == 1)));
      end
    end
  end

  task automatic op(bit w, int a, int d);
    @(negedge clk);
    wr_en = w; addr = AW'(a); wdata = DW'(d);
  endtask

  localparam int P1 = PBASE + 1*NREG;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R1";
    for (int a = 0; a < 3; a++) op(0, a, 0);
    tag = "R6";
    op(1, P1 + 1, 8'hA5); op(0, P1 + 1, 0); op(0, P1 + 3, 0); op(0, P1 + 3, 0);
    op(1, P1 + 0, 8'h01); op(0, P1 + 3, 0); op(0, P1 + 3, 0); op(0, P1 + 3, 0);
    tag = "R8";
    op(1, P1 + 3, 8'hFE); op(0, P1 + 3, 0); op(0, P1 + 3, 0); op(0, P1 + 3, 0);
    tag = "R3";
    op(1, 0, 8'h02); op(1, P1 + 1, 8'h33); op(0, P1 + 1, 0); op(0, P1 + 3, 0);
    tag = "R5";
    op(1, 0, 8'h00);
    for (int r = 0; r < NREG; r++) op(0, P1 + r, 0);
    tag = "R1";
    op(1, 2, 8'hFF); op(0, 2, 0); op(1, 0, 8'hFF); op(0, 0, 0); op(1, 1, 8'hFF); op(0, 1, 0);
    op(1, 0, 8'h00);
    tag = "R9";
    op(1, 5, 8'h77); op(0, 5, 0); op(1, 8'h80, 8'h11); op(0, 8'h80, 0);
    tag = "R6";
    for (int i = 0; i < 2000; i++) begin
      int a, k;
      k = $urandom_range(0, 9);
      if (k == 0) a = $urandom_range(0, 2);
      else if (k == 1) a = $urandom_range(3, 255);
      else a = PBASE + $urandom_range(0, NPER*NREG - 1);
      op($urandom_range(0, 2) != 0, a, $urandom_range(0, 255));
    end
    op(0, 0, 0);
    @(negedge clk);
    done = 1;
    #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

  initial begin
    #500000;
    nbad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule